// File: doc/BRIEF.md
# Serial Byte Receiver with Status Flags

This block receives asynchronous serial frames on a single input line and places each received byte into one holding register. A clock enable pulsing at sixteen times the bit rate paces all sampling. A frame is a low start bit, eight data bits sent least significant first, an optional parity bit, and a high stop bit. The line idles high.

The receiver leaves the frame at the middle of the stop bit, not at its end. This lets it lock onto the next start edge as early as possible, even when the far transmitter runs slightly fast. Alongside the byte it reports five flags: a holding register that is full, a frame in progress, a bad stop bit, a parity mismatch, and an overrun. A single-cycle read strobe marks the holding register as consumed. The same strobe clears the error flags.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, rx_data is 0 and buf_full, rx_busy, frame_err, par_err and ovr_err are all 0.
- R2: The line is sampled once per bit at mid-bit, paced by sixteen tick pulses per bit. Bits arrive least significant first, and a received byte appears on rx_data.
- R3: A low pulse on the line shorter than half a bit period is rejected when the start bit is confirmed at mid-bit. rx_data and buf_full keep their values.
- R4: rx_busy is 1 from start detection until the stop-bit sample, or until a start is rejected. It never holds after the frame.
- R5: At the stop-bit sample the receiver returns to idle whatever the stop value was. rx_busy is therefore 0 before the stop bit ends.
- R6: Loading a byte sets buf_full and a read strobe clears it. When a load and a read fall in the same cycle, the load wins.
- R7: frame_err is 1 for a byte whose stop bit was sampled as 0, and 0 for a byte whose stop bit was sampled as 1.
- R8: When par_en is 1, a parity bit follows data bit 7. With par_odd = 0 the expected parity bit is the XOR of the eight data bits; with par_odd = 1 it is the inverse of that XOR. par_err is 1 on a mismatch. When par_en is 0, no parity bit is taken and par_err is 0.
- R9: A byte that completes while buf_full is 1 sets ovr_err and replaces the unread byte. ovr_err rises one cycle before rx_data takes the new byte.
- R10: A read strobe clears frame_err, par_err and ovr_err. Each load replaces frame_err and par_err with the new byte's status, and ovr_err holds until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, sixteen pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Holding register |
| buf_full | output | 1 | Holding register holds an unread byte |
| rx_busy | output | 1 | Frame in progress |
| frame_err | output | 1 | Stop bit sampled as 0 |
| par_err | output | 1 | Parity mismatch |
| ovr_err | output | 1 | Unread byte was overwritten |

## Verification
The read strobe can land in the same cycle as a byte load, and the overrun check can coincide with a read. The bench provokes the first case directly. It waits for rx_busy to fall at the stop sample and pulses rd_stb in the very next cycle, which is the load cycle. It then expects buf_full to stay at 1, the new byte to be present, and ovr_err to be clear. A second directed frame lands on a full register and samples the cycle in which ovr_err rises. It expects the old byte still visible in that cycle and the new byte one cycle later. Random frames with random reads and injected parity and stop faults then check every flag against a bench model.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } urx_st_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] ff_q;
  logic              prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q  <= {STAGES{RST_VAL}};
      prv_q <= RST_VAL;
    end else begin
      ff_q  <= {ff_q[STAGES-2:0], din};
      prv_q <= ff_q[STAGES-1];
    end
  end

  assign dout = ff_q[STAGES-1];
  assign fall = prv_q & ~ff_q[STAGES-1];
endmodule

// File: rtl/urx_fsm.sv
module urx_fsm
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              fall,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              busy,
  output logic              stop_hit,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              fe,
  output logic              pe
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W);
  localparam int HALF = OSR / 2;

  urx_st_e           st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic [DATA_W-1:0] shf_q, shf_n, data_q, data_n;
  logic              parb_q, parb_n, done_q, done_n, fe_q, fe_n, pe_q, pe_n;
  logic              mid_hit, end_hit;

  assign mid_hit = tick && (cnt_q == CW'(HALF - 1));
  assign end_hit = tick && (cnt_q == CW'(OSR - 1));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    shf_n  = shf_q;
    parb_n = parb_q;
    done_n = 1'b0;
    data_n = data_q;
    fe_n   = fe_q;
    pe_n   = pe_q;
    if (tick && st_q != ST_IDLE)
      cnt_n = (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (fall) begin
          st_n  = ST_START;
          cnt_n = '0;
        end
      end
      ST_START: begin
        if (mid_hit) begin
          cnt_n = '0;
          idx_n = '0;
          st_n  = rx_s ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (end_hit) begin
          shf_n = {rx_s, shf_q[DATA_W-1:1]};
          if (idx_q == IW'(DATA_W - 1)) st_n = par_en ? ST_PAR : ST_STOP;
          else                          idx_n = idx_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (end_hit) begin
          parb_n = rx_s;
          st_n   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (end_hit) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          data_n = shf_q;
          fe_n   = ~rx_s;
          pe_n   = par_en & (parb_q ^ (^shf_q) ^ par_odd);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      shf_q  <= '0;
      parb_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      shf_q  <= shf_n;
      parb_q <= parb_n;
      done_q <= done_n;
      data_q <= data_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign stop_hit = (st_q == ST_STOP) && end_hit;
  assign done     = done_q;
  assign data     = data_q;
  assign fe       = fe_q;
  assign pe       = pe_q;
endmodule

// File: rtl/urx_status.sv
module urx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_hit,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  input  logic              fe_in,
  input  logic              pe_in,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              frame_err,
  output logic              par_err,
  output logic              ovr_err
);
  logic [DATA_W-1:0] dat_q, dat_n;
  logic              full_q, full_n, fe_q, fe_n, pe_q, pe_n, ovr_q, ovr_n;

  always_comb begin
    dat_n  = dat_q;
    full_n = full_q;
    fe_n   = fe_q;
    pe_n   = pe_q;
    ovr_n  = ovr_q;
    if (load) begin
      dat_n  = d_in;
      full_n = 1'b1;
      fe_n   = fe_in;
      pe_n   = pe_in;
    end else if (rd_stb) begin
      full_n = 1'b0;
      fe_n   = 1'b0;
      pe_n   = 1'b0;
    end
    if (stop_hit && full_q && !rd_stb) ovr_n = 1'b1;
    else if (rd_stb)                   ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      dat_q  <= dat_n;
      full_q <= full_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
      ovr_q  <= ovr_n;
    end
  end

  assign rx_data   = dat_q;
  assign buf_full  = full_q;
  assign frame_err = fe_q;
  assign par_err   = pe_q;
  assign ovr_err   = ovr_q;
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W   = 8,
  parameter int OSR      = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              rx_busy,
  output logic              frame_err,
  output logic              par_err,
  output logic              ovr_err
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic              rx_s, rx_fall, stop_hit, frm_done, frm_fe, frm_pe;
  logic [DATA_W-1:0] frm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  urx_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_sn), .din(rxd), .dout(rx_s), .fall(rx_fall)
  );

  urx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) i_fsm (
    .clk(clk), .rst_n(rst_sn), .tick(tick), .rx_s(rx_s), .fall(rx_fall),
    .par_en(par_en), .par_odd(par_odd), .busy(rx_busy), .stop_hit(stop_hit),
    .done(frm_done), .data(frm_data), .fe(frm_fe), .pe(frm_pe)
  );

  urx_status #(.DATA_W(DATA_W)) i_status (
    .clk(clk), .rst_n(rst_sn), .stop_hit(stop_hit), .load(frm_done),
    .d_in(frm_data), .fe_in(frm_fe), .pe_in(frm_pe), .rd_stb(rd_stb),
    .rx_data(rx_data), .buf_full(buf_full), .frame_err(frame_err),
    .par_err(par_err), .ovr_err(ovr_err)
  );
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_stb,
  input logic rx_busy,
  input logic buf_full,
  input logic frame_err,
  input logic par_err,
  input logic ovr_err,
  input logic frm_done,
  input logic stop_hit
);
  a_r6_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> buf_full);

  a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !frm_done) |=> !buf_full);

  a_r5_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !rx_busy);

  a_r9_ovr_leads_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> frm_done);

  a_r9_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> buf_full);

  a_r10_err_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || par_err) |-> buf_full);
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rx_busy(rx_busy),
  .buf_full(buf_full), .frame_err(frame_err), .par_err(par_err),
  .ovr_err(ovr_err), .frm_done(frm_done), .stop_hit(stop_hit)
);

// File: tb/test_uart_rx_flags.sv
module test_uart_rx_flags;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int TK         = 2;
  localparam int BITC       = OSR * TK;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_stb = 1'b0;
  logic       tick;
  logic [7:0] rx_data;
  logic       buf_full, rx_busy, frame_err, par_err, ovr_err;

  int n_vec = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  int tk_cnt = 0;

  logic [7:0] e_data = 8'h00;
  bit e_full = 0, e_fe = 0, e_pe = 0, e_ovr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tk_cnt <= (tk_cnt == TK - 1) ? 0 : tk_cnt + 1;
  assign tick = (tk_cnt == 0);

  uart_rx_flags i_uart_rx_flags (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .rd_stb(rd_stb), .rx_data(rx_data), .buf_full(buf_full),
    .rx_busy(rx_busy), .frame_err(frame_err), .par_err(par_err), .ovr_err(ovr_err)
  );

  function automatic bit par_bit(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 data"}, rx_data, e_data);
    chk({tag, " R6 full"}, buf_full, e_full);
    chk({tag, " R7 frame_err"}, frame_err, e_fe);
    chk({tag, " R8 par_err"}, par_err, e_pe);
    chk({tag, " R9 ovr_err"}, ovr_err, e_ovr);
  endtask

  task automatic send_raw(input logic [7:0] d, input bit pen, input bit podd,
                          input bit badp, input bit bads);
    par_en = pen;
    par_odd = podd;
    rxd = 1'b0;
    cyc(10);
    chk("R4 busy during start bit", rx_busy, 1);
    cyc(BITC - 10);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      cyc(BITC);
    end
    if (pen) begin
      rxd = par_bit(d, podd) ^ badp;
      cyc(BITC);
    end
    rxd = bads ? 1'b0 : 1'b1;
    cyc(26);
    chk("R5 idle before stop bit ends", rx_busy, 0);
    cyc(BITC - 26);
    rxd = 1'b1;
  endtask

  task automatic model_load(input logic [7:0] d, input bit pen, input bit badp, input bit bads);
    e_ovr  = e_ovr | e_full;
    e_full = 1;
    e_data = d;
    e_fe   = bads;
    e_pe   = pen & badp;
  endtask

  task automatic frame(input string tag, input logic [7:0] d, input bit pen, input bit podd,
                       input bit badp, input bit bads);
    send_raw(d, pen, podd, badp, bads);
    model_load(d, pen, badp, bads);
    cyc(4);
    check_all(tag);
  endtask

  task automatic do_read(input string tag);
    rd_stb = 1'b1;
    cyc(1);
    rd_stb = 1'b0;
    e_full = 0; e_fe = 0; e_pe = 0; e_ovr = 0;
    cyc(1);
    chk({tag, " R6 read clears full"}, buf_full, 0);
    chk({tag, " R10 read clears frame_err"}, frame_err, 0);
    chk({tag, " R10 read clears par_err"}, par_err, 0);
    chk({tag, " R10 read clears ovr_err"}, ovr_err, 0);
    chk({tag, " R6 data kept after read"}, rx_data, e_data);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    void'($urandom(32'h0bad_cafe));
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 data", rx_data, 0);
    chk("R1 full", buf_full, 0);
    chk("R1 busy", rx_busy, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 par_err", par_err, 0);
    chk("R1 ovr_err", ovr_err, 0);

    frame("R2 plain", 8'hA5, 0, 0, 0, 0);
    do_read("R6 first");
    frame("R8 even ok", 8'h3C, 1, 0, 0, 0);
    do_read("r8a");
    frame("R8 odd ok", 8'h71, 1, 1, 0, 0);
    do_read("r8b");
    frame("R8 even bad", 8'h0F, 1, 0, 1, 0);
    do_read("r8c");
    frame("R8 odd bad", 8'hE2, 1, 1, 1, 0);
    do_read("r8d");
    frame("R8 disabled", 8'h81, 0, 0, 1, 0);
    do_read("r8e");
    frame("R7 bad stop", 8'h5E, 0, 0, 0, 1);
    cyc(8);
    frame("R10 replace and overrun", 8'h12, 1, 0, 0, 0);
    do_read("r10");

    frame("R9 fill", 8'h66, 0, 0, 0, 0);
    old = rx_data;
    fork
      send_raw(8'h99, 0, 0, 0, 0);
      begin
        for (int k = 0; k < 2000 && !ovr_err; k++) cyc(1);
        chk("R9 overrun rose", ovr_err, 1);
        chk("R9 old byte while overrun rises", rx_data, old);
        cyc(1);
        chk("R9 new byte one cycle later", rx_data, 8'h99);
      end
    join
    model_load(8'h99, 0, 0, 0);
    cyc(4);
    check_all("R9 after overrun");

    fork
      send_raw(8'hC3, 1, 1, 0, 0);
      begin
        for (int k = 0; k < 2000 && !rx_busy; k++) cyc(1);
        for (int k = 0; k < 2000 && rx_busy; k++) cyc(1);
        rd_stb = 1'b1;
        cyc(1);
        rd_stb = 1'b0;
      end
    join
    e_full = 1; e_ovr = 0; e_data = 8'hC3; e_fe = 0; e_pe = 0;
    cyc(4);
    check_all("R6 read coincides with load");
    do_read("r6c");

    frame("R3 fill", 8'h44, 0, 0, 0, 0);
    rxd = 1'b0;
    cyc(6);
    rxd = 1'b1;
    cyc(2);
    chk("R4 busy on glitch start", rx_busy, 1);
    cyc(28);
    chk("R4 busy released after glitch", rx_busy, 0);
    chk("R3 glitch leaves data", rx_data, 8'h44);
    chk("R3 glitch leaves full", buf_full, 1);
    chk("R3 no overrun from glitch", ovr_err, 0);
    do_read("r3");

    for (int n = 0; n < 60; n++) begin
      logic [7:0] d;
      bit pen, podd, badp, bads;
      d    = 8'($urandom);
      pen  = 1'($urandom % 2);
      podd = 1'($urandom % 2);
      badp = ($urandom % 6) == 0;
      bads = ($urandom % 6) == 0;
      if ($urandom % 2) do_read("R6 random read");
      frame("R2 random", d, pen, podd, badp, bads);
      cyc(int'($urandom % 20));
    end

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule